// File: doc/BRIEF.md
# Serial Sample Frame Assembler

This block sits between a byte-wide serial receiver and the image buffer of a small digit classifier. Received bytes arrive one at a time, each marked by a one-cycle valid strobe. The block pairs them, low byte first, into signed 16-bit fixed-point samples with one sign bit and fifteen fraction bits. It writes each sample into the buffer at the next sequential address. When the last sample of a frame (784 by default) has been written, it raises a one-cycle ready pulse so that inference can start.

If the sender stalls part way through a frame, a programmable inter-byte timeout throws away the partial frame, so the next byte starts a fresh frame. While the classifier reports itself busy, incoming bytes are dropped so the buffer being read stays intact. In the other direction, the block holds the predicted digit and offers it to the serial transmitter as one byte. The byte stays on offer until the transmitter accepts it.

The frame control is a four-state machine:
- ST_WAIT_LO waits for the low byte of a word.
- ST_WAIT_HI waits for the high byte.
- ST_COMMIT covers the cycle in which the final word's write is on the buffer port.
- ST_READY is the cycle of the ready pulse.

Its transitions are:
- lo_taken: ST_WAIT_LO to ST_WAIT_HI when a byte is accepted.
- word_done: ST_WAIT_HI back to ST_WAIT_LO when a high byte completes a word that is not the last.
- frame_done: ST_WAIT_HI to ST_COMMIT when the high byte of the last word is accepted.
- publish: ST_COMMIT to ST_READY, unconditionally.
- rearm: ST_READY to ST_WAIT_LO, unconditionally.
- abort: from ST_WAIT_HI, or from ST_WAIT_LO part way through a frame, back to ST_WAIT_LO with the word count cleared, when the timeout expires.

Top module: `sample_frame_assembler`

## Requirements
- R1: While reset is asserted, buf_we, frame_ready and tx_valid are 0. After reset, even one that interrupts a frame, the next accepted byte is the low byte of the word at address 0.
- R2: A word is formed as {second byte, first byte}: the first accepted byte of a pair goes to bits 7:0 and the second to bits 15:8. buf_we is high for exactly one cycle, the cycle after the high byte is accepted, with buf_data holding the word.
- R3: The words of a frame are written to addresses 0, 1, 2 … NUM_WORDS-1 in arrival order, with one write per word.
- R4: frame_ready is high for exactly one cycle, the cycle right after the write of word NUM_WORDS-1. There is exactly one pulse per completed frame. Bytes that arrive during the write cycle or the pulse cycle are dropped.
- R5: After a completed frame, the next word is written to address 0.
- R6: Part way through a frame (a low byte held, or at least one word written), if idle_limit consecutive clock edges pass with no accepted byte, the partial frame is discarded without a ready pulse, and the next byte is the low byte of word 0. A gap of idle_limit-1 idle edges does not abort the frame.
- R7: idle_limit = 0 disables the timeout.
- R8: While core_busy is 1, rx_valid is ignored. No write takes place and the byte pairing does not advance.
- R9: A result_valid pulse loads result_digit. tx_valid then rises in the next cycle, with tx_byte = {4'b0000, digit}. Both hold steady while tx_ready is 0.
- R10: After a cycle with tx_valid and tx_ready both high, tx_valid is 0 in the next cycle, so the byte is sent only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking rx_byte |
| idle_limit | input | 16 | Inter-byte timeout in clock cycles, 0 disables |
| core_busy | input | 1 | Classifier is reading the buffer; bytes are dropped |
| buf_addr | output | 10 | Image buffer write address |
| buf_data | output | 16 | Image buffer write data (signed sample) |
| buf_we | output | 1 | Image buffer write enable |
| frame_ready | output | 1 | One-cycle pulse: frame complete |
| result_digit | input | 4 | Predicted digit 0–9 |
| result_valid | input | 1 | One-cycle strobe marking result_digit |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_byte | output | 8 | Byte returned to the sender |
| tx_valid | output | 1 | tx_byte is on offer |

## Verification
The bound checker checks the following on every cycle:
- A write is never followed directly by another write.
- Every write stays inside the buffer and follows an accepted byte taken while the classifier was idle.
- The ready pulse lasts one cycle and comes straight after a write to the last address.
- The outgoing byte stays put until handshaked and is withdrawn right after.

Only the bench's scenarios can show the rest:
- The little-endian word values and the full address sequence of a frame.
- The exact edge at which the timeout discards a frame, against a gap one cycle shorter.
- That bytes taken in while busy leave no trace in the pairing.
- That a reset or a timeout part way through a frame restarts at address 0.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_LO = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_READY   = 2'd3
    } asm_state_t;

endpackage

// File: rtl/sfa_idle_timer.sv
// Counts consecutive idle edges while a frame is open; flags expiry.
module sfa_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             kick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W:0]   idle_next;

    assign idle_next = {1'b0, idle_cnt} + 1'b1;
    assign expire    = active && !kick && (limit != '0)
                       && (idle_next >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!active || kick || expire) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/sfa_result_tx.sv
// Holds the predicted digit as one byte until the transmitter takes it.
module sfa_result_tx #(
    parameter int DIGIT_W = 4,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               result_valid,
    input  logic [DIGIT_W-1:0] result_digit,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_byte
);

    localparam int PAD_W = BYTE_W - DIGIT_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else if (result_valid) begin
            tx_valid <= 1'b1;
            tx_byte  <= {{PAD_W{1'b0}}, result_digit};
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sample_frame_assembler.sv
module sample_frame_assembler
    import sfa_pkg::*;
#(
    parameter int NUM_WORDS = 784,
    parameter int BYTE_W    = 8,
    parameter int TMO_W     = 16,
    parameter int DIGIT_W   = 4,
    localparam int WORD_W   = 2 * BYTE_W,
    localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               rx_valid,
    input  logic [TMO_W-1:0]   idle_limit,
    input  logic               core_busy,
    output logic [ADDR_W-1:0]  buf_addr,
    output logic [WORD_W-1:0]  buf_data,
    output logic               buf_we,
    output logic               frame_ready,
    input  logic [DIGIT_W-1:0] result_digit,
    input  logic               result_valid,
    input  logic               tx_ready,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               tx_valid
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

    asm_state_t        state, state_nxt;
    logic [ADDR_W-1:0] word_cnt;
    logic [BYTE_W-1:0] lo_q;
    logic              accept;
    logic              in_frame;
    logic              tmo;
    logic              last_word;

    assign accept    = rx_valid && !core_busy
                       && ((state == ST_WAIT_LO) || (state == ST_WAIT_HI));
    assign in_frame  = (state == ST_WAIT_HI)
                       || ((state == ST_WAIT_LO) && (word_cnt != '0));
    assign last_word = (word_cnt == LAST_ADDR);

    sfa_idle_timer #(
        .CNT_W (TMO_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_frame),
        .kick   (accept),
        .limit  (idle_limit),
        .expire (tmo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_LO;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_LO: begin
                if (tmo) begin
                    state_nxt = ST_WAIT_LO;          // abort
                end else if (accept) begin
                    state_nxt = ST_WAIT_HI;          // lo_taken
                end
            end
            ST_WAIT_HI: begin
                if (tmo) begin
                    state_nxt = ST_WAIT_LO;          // abort
                end else if (accept) begin
                    state_nxt = last_word ? ST_COMMIT   // frame_done
                                          : ST_WAIT_LO; // word_done
                end
            end
            ST_COMMIT: state_nxt = ST_READY;         // publish
            ST_READY:  state_nxt = ST_WAIT_LO;       // rearm
        endcase
    end

    // Outputs
    assign frame_ready = (state == ST_READY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_cnt <= '0;
            lo_q     <= '0;
            buf_we   <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
        end else begin
            buf_we <= 1'b0;
            if (tmo) begin
                word_cnt <= '0;
            end else if (accept && (state == ST_WAIT_LO)) begin
                lo_q <= rx_byte;
            end else if (accept && (state == ST_WAIT_HI)) begin
                buf_we   <= 1'b1;
                buf_addr <= word_cnt;
                buf_data <= {rx_byte, lo_q};
                word_cnt <= last_word ? '0 : word_cnt + 1'b1;
            end
        end
    end

    sfa_result_tx #(
        .DIGIT_W (DIGIT_W),
        .BYTE_W  (BYTE_W)
    ) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .result_valid (result_valid),
        .result_digit (result_digit),
        .tx_ready     (tx_ready),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte)
    );

endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
    parameter int NUM_WORDS = 784,
    parameter int BYTE_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              core_busy,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              frame_ready,
    input logic              result_valid,
    input logic              tx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte
);

    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> !buf_we);

    a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr < ADDR_W'(NUM_WORDS)));

    a_r4_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |=> !frame_ready);

    a_r4_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> ($past(buf_we) && ($past(buf_addr) == ADDR_W'(NUM_WORDS - 1))));

    a_r8_write_needs_idle_core: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> ($past(rx_valid) && !$past(core_busy)));

    a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !result_valid) |=> (tx_valid && $stable(tx_byte)));

    a_r10_tx_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !result_valid) |=> !tx_valid);

endmodule

bind sample_frame_assembler sfa_checker #(
    .NUM_WORDS (NUM_WORDS),
    .BYTE_W    (BYTE_W)
) u_sfa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .core_busy    (core_busy),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .frame_ready  (frame_ready),
    .result_valid (result_valid),
    .tx_ready     (tx_ready),
    .tx_valid     (tx_valid),
    .tx_byte      (tx_byte)
);

// File: tb/tb_sample_frame_assembler.sv
`timescale 1ns/1ps
module tb_sample_frame_assembler;

    localparam int NW  = 784;
    localparam int LIM = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] idle_limit = 16'(LIM);
    logic        core_busy = 1'b0;
    logic [9:0]  buf_addr;
    logic [15:0] buf_data;
    logic        buf_we;
    logic        frame_ready;
    logic [3:0]  result_digit = '0;
    logic        result_valid = 1'b0;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_cnt = 0, rdy_cnt = 0, last_we_cyc = 0, rdy_cyc = 0;
    int last_addr = 0, last_data = 0;
    logic [15:0] mem [NW];

    always #2 clk = ~clk;

    sample_frame_assembler dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .idle_limit(idle_limit), .core_busy(core_busy),
        .buf_addr(buf_addr), .buf_data(buf_data), .buf_we(buf_we),
        .frame_ready(frame_ready), .result_digit(result_digit),
        .result_valid(result_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                wr_cnt++;
                last_addr = int'(buf_addr);
                last_data = int'(buf_data);
                last_we_cyc = cyc;
                mem[buf_addr] = buf_data;
            end
            if (frame_ready) begin
                rdy_cnt++;
                rdy_cyc = cyc;
            end
        end
    end

    // {low byte, high byte, expected word}
    localparam logic [31:0] TBL [8] = '{
        {8'h34, 8'h12, 16'h1234}, {8'h00, 8'h80, 16'h8000},
        {8'hFF, 8'h7F, 16'h7FFF}, {8'hFF, 8'hFF, 16'hFFFF},
        {8'h00, 8'h00, 16'h0000}, {8'h01, 8'h00, 16'h0001},
        {8'h00, 8'h01, 16'h0100}, {8'hCD, 8'hAB, 16'hABCD}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_word(input logic [7:0] lo, input logic [7:0] hi);
        send_byte(lo);
        send_byte(hi);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'(k * 37) ^ 16'hA5C3;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        int wr0;
        // R1: reset state
        idle(3);
        #1;
        chk("R1 we", int'(buf_we), 0);
        chk("R1 ready", int'(frame_ready), 0);
        chk("R1 tx_valid", int'(tx_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: table of words at the start of a frame
        for (int k = 0; k < 8; k++) begin
            send_word(TBL[k][31:24], TBL[k][23:16]);
            chk("R2 data", last_data, int'(TBL[k][15:0]));
            chk("R3 addr", last_addr, k);
        end
        for (int k = 8; k < NW; k++) begin
            logic [15:0] w;
            w = pat(k);
            send_word(w[7:0], w[15:8]);
        end
        idle(4);
        #1;
        bad = 0;
        for (int k = 8; k < NW; k++) if (mem[k] !== pat(k)) bad++;
        chk("R3 frame contents", bad, 0);
        chk("R3 write count", wr_cnt, NW);
        chk("R4 ready count", rdy_cnt, 1);
        chk("R4 ready timing", rdy_cyc, last_we_cyc + 1);

        // R5: next frame restarts at 0
        send_word(8'h11, 8'h22);
        chk("R5 addr", last_addr, 0);
        chk("R5 data", last_data, 16'h2211);

        // R6: gap of LIM-1 idle edges keeps the frame
        send_byte(8'h55);
        idle(LIM - 2);
        send_byte(8'h66);
        #1;
        chk("R6 short gap addr", last_addr, 1);
        chk("R6 short gap data", last_data, 16'h6655);
        // R6: gap of LIM idle edges aborts; partial word discarded
        send_byte(8'h77);
        idle(LIM - 1);
        send_word(8'h88, 8'h99);
        chk("R6 abort addr", last_addr, 0);
        chk("R6 abort data", last_data, 16'h9988);
        chk("R6 no ready", rdy_cnt, 1);
        idle(LIM + 10);

        // R8: bytes ignored while busy
        wr0 = wr_cnt;
        core_busy = 1'b1;
        send_byte(8'hAA);
        send_byte(8'hBB);
        send_byte(8'hCC);
        #1;
        chk("R8 no write while busy", wr_cnt, wr0);
        core_busy = 1'b0;
        send_word(8'h01, 8'h02);
        chk("R8 addr", last_addr, 0);
        chk("R8 data", last_data, 16'h0201);

        // R7: idle_limit 0 disables the timeout
        idle_limit = '0;
        send_byte(8'h10);
        idle(60);
        send_byte(8'h20);
        #1;
        chk("R7 addr", last_addr, 1);
        chk("R7 data", last_data, 16'h2010);
        idle_limit = 16'(LIM);
        idle(LIM + 10);

        // R1: reset part way through a frame
        send_word(8'h01, 8'h01);
        send_byte(8'h5A);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        #1;
        chk("R1 we in reset", int'(buf_we), 0);
        chk("R1 ready in reset", int'(frame_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        send_word(8'h3C, 8'h4D);
        chk("R1 restart addr", last_addr, 0);
        chk("R1 restart data", last_data, 16'h4D3C);

        // R9/R10: result byte return path
        @(negedge clk);
        result_digit = 4'd7;
        result_valid = 1'b1;
        @(negedge clk);
        result_valid = 1'b0;
        #1;
        chk("R9 tx_valid", int'(tx_valid), 1);
        chk("R9 tx_byte", int'(tx_byte), 8'h07);
        idle(5);
        #1;
        chk("R9 hold valid", int'(tx_valid), 1);
        chk("R9 hold byte", int'(tx_byte), 8'h07);
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        #1;
        chk("R10 drop after handshake", int'(tx_valid), 0);

        @(negedge clk);
        tx_ready = 1'b1;
        result_digit = 4'd9;
        result_valid = 1'b1;
        @(negedge clk);
        result_valid = 1'b0;
        #1;
        chk("R9 digit 9 valid", int'(tx_valid), 1);
        chk("R9 digit 9 byte", int'(tx_byte), 8'h09);
        @(negedge clk);
        #1;
        chk("R10 single send", int'(tx_valid), 0);
        tx_ready = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule